// File: doc/BRIEF.md
# Three-State Phase-Frequency Comparator

This block is a synchronous, oversampled digital model of the sequential phase-frequency comparator that sits at the front of a phase-locked loop. A system clock samples two asynchronous single-bit signals. The first is the reference and the second is the divided oscillator feedback. Each signal passes through a two-flop synchronizer and then a rising-edge detector. Only rising edges matter, so the duty cycle of either input has no effect.

A three-state machine turns the edge events into a two-bit correction code, `corr_o = {up, down}`. The code asks the charge pump to raise the oscillator frequency, to lower it, or to do nothing. Code 00 is the undriven, high-impedance state, and code 11 never appears.

- When the reference leads, the machine requests up until the feedback edge arrives.
- When the feedback leads, it requests down until the reference edge arrives.
- When the loop is locked, the two edges coincide and the output stays undriven for almost the whole cycle.
- When the reference stops, the machine requests down indefinitely, so the oscillator settles at its lowest frequency.

Lock and capture are decided by edge order alone, so both ranges are the same and neither depends on a filter setting.

The registered `pulse_o` output is high whenever the comparator is undriven. A lock qualifier counts consecutive reference cycles in which no correction pulse lasts longer than one system clock. It raises `lock_o` once that count reaches `LOCK_CYCLES`.

States:
- `ST_IDLE`: undriven.
- `ST_UP`: frequency-raise request.
- `ST_DN`: frequency-lower request.

Transitions:
- `ST_IDLE`→`ST_UP`: a reference rise arrives alone.
- `ST_IDLE`→`ST_DN`: a feedback rise arrives alone.
- `ST_IDLE`→`ST_IDLE`: both rises arrive together, or neither arrives.
- `ST_UP`→`ST_IDLE`: a feedback rise arrives.
- `ST_UP`→`ST_UP`: only reference rises, or nothing, arrive.
- `ST_DN`→`ST_IDLE`: a reference rise arrives.
- `ST_DN`→`ST_DN`: only feedback rises, or nothing, arrive.

Top module: `pfd_comparator`

## Requirements
- R1: While reset is asserted and after it is released, `corr_o` is 00, `pulse_o` is 1 and `lock_o` is 0.
- R2: In the undriven state, a lone reference rise gives `corr_o` = 10 (bit 1 = up) on the third clock edge after the input changes, and not before.
- R3: In the undriven state, a lone feedback rise gives `corr_o` = 01 (bit 0 = down) on the third clock edge after the input changes.
- R4: While up is requested, a feedback rise returns `corr_o` to 00. While down is requested, a reference rise returns `corr_o` to 00. Latency is again three edges.
- R5: While up is requested, further reference rises keep `corr_o` at 10.
- R6: Reference and feedback rises detected on the same clock leave an undriven comparator at 00.
- R7: `corr_o` never equals 11.
- R8: `pulse_o` is high exactly when `corr_o` is 00.
- R9: Falling edges on either input do not change `corr_o`.
- R10: With no reference rises, feedback rises hold `corr_o` at 01 continuously.
- R11: `lock_o` rises on the `LOCK_CYCLES`-th consecutive reference rise in which no correction pulse has exceeded one clock, and not earlier.
- R12: A correction that stays active for two consecutive clocks clears `lock_o`. A one-clock pulse does not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Asynchronous reference signal |
| fb_in | input | 1 | Asynchronous feedback signal |
| corr_o | output | 2 | Correction code {up, down}; 00 = undriven |
| pulse_o | output | 1 | Registered high while undriven |
| lock_o | output | 1 | Lock qualified over `LOCK_CYCLES` reference cycles |

## Verification
The comparator is driven with the following isolated edge patterns:
- A reference lead separates up from down.
- A feedback lead checks the mirror path.
- Coincident rises confirm that no spurious pulse appears.
- Repeated same-side rises expose a machine that re-triggers wrongly.
- Falling-only steps expose edge detectors that respond to the wrong polarity.

A feedback train with no reference confirms that down is held for a whole run. Periodic waves compare three phase offsets:
- An offset of zero clocks builds lock over exactly `LOCK_CYCLES` reference periods.
- An offset of one clock must keep lock.
- An offset of two clocks must drop it.

These three cases separate the pulse-width limit from the counting.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Comparator states; the encoding doubles as the {up, down} output code.
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_UP   = 2'b10,
        ST_DN   = 2'b01
    } pfd_state_e;

    localparam int CORR_W      = 2;
    localparam int CORR_UP_BIT = 1;
    localparam int CORR_DN_BIT = 0;

    localparam logic [CORR_W-1:0] CODE_OFF  = 2'b00;
    localparam logic [CORR_W-1:0] CODE_UP   = 2'b10;
    localparam logic [CORR_W-1:0] CODE_DOWN = 2'b01;

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic rise_o
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              hist_q;

    // First stage captures the asynchronous input.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q[0] <= 1'b0;
        end else begin
            sync_q[0] <= d_i;
        end
    end

    // Remaining synchronizer stages.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q[g] <= 1'b0;
            end else begin
                sync_q[g] <= sync_q[g-1];
            end
        end
    end

    // Delayed copy of the synchronized level, for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= 1'b0;
        end else begin
            hist_q <= sync_q[LAST];
        end
    end

    assign rise_o = sync_q[LAST] & ~hist_q;

    // R9
    falling_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_q && !sync_q[LAST]) |-> !rise_o);

endmodule

// File: rtl/pfd_fsm.sv
module pfd_fsm
    import pfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_rise_i,
    input  logic              fb_rise_i,
    output logic [CORR_W-1:0] corr_o,
    output logic              active_o,
    output logic              idle_o
);

    pfd_state_e state_q;
    pfd_state_e state_d;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_rise_i && !fb_rise_i) begin
                    state_d = ST_UP;
                end else if (fb_rise_i && !ref_rise_i) begin
                    state_d = ST_DN;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_UP: begin
                if (fb_rise_i) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_UP;
                end
            end
            ST_DN: begin
                if (ref_rise_i) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_DN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode from the registered state.
    always_comb begin
        corr_o   = CODE_OFF;
        active_o = 1'b0;
        idle_o   = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                corr_o   = CODE_OFF;
                active_o = 1'b0;
                idle_o   = 1'b1;
            end
            ST_UP: begin
                corr_o   = CODE_UP;
                active_o = 1'b1;
                idle_o   = 1'b0;
            end
            ST_DN: begin
                corr_o   = CODE_DOWN;
                active_o = 1'b1;
                idle_o   = 1'b0;
            end
            default: begin
                corr_o   = CODE_OFF;
                active_o = 1'b0;
                idle_o   = 1'b1;
            end
        endcase
    end

    // R2
    ref_lead_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ref_rise_i && !fb_rise_i) |=> corr_o == CODE_UP);

    // R3
    fb_lead_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && fb_rise_i && !ref_rise_i) |=> corr_o == CODE_DOWN);

    // R4
    up_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_o == CODE_UP && fb_rise_i) |=> corr_o == CODE_OFF);

    // R4
    down_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_o == CODE_DOWN && ref_rise_i) |=> corr_o == CODE_OFF);

    // R6
    coincident_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_o == CODE_OFF && ref_rise_i && fb_rise_i) |=> corr_o == CODE_OFF);

    // R10
    down_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_o == CODE_DOWN && !ref_rise_i) |=> corr_o == CODE_DOWN);

endmodule

// File: rtl/pfd_lock_qual.sv
module pfd_lock_qual #(
    parameter int LOCK_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic ref_rise_i,
    output logic lock_o
);

    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_CYCLES);

    logic [CNT_W-1:0] good_q;
    logic             prev_active_q;
    logic             wide_now;

    // A correction pulse is too wide once it is active on two clocks in a row.
    assign wide_now = active_i & prev_active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_active_q <= 1'b0;
        end else begin
            prev_active_q <= active_i;
        end
    end

    // Count clean reference cycles, saturating at the threshold.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_q <= '0;
        end else if (wide_now) begin
            good_q <= '0;
        end else if (ref_rise_i && good_q != CNT_MAX) begin
            good_q <= good_q + 1'b1;
        end
    end

    assign lock_o = (good_q == CNT_MAX);

    // R12
    wide_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wide_now |=> !lock_o);

    // R11
    lock_on_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(ref_rise_i));

endmodule

// File: rtl/pfd_comparator.sv
module pfd_comparator
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic              fb_in,
    output logic [CORR_W-1:0] corr_o,
    output logic              pulse_o,
    output logic              lock_o
);

    localparam int N_IN   = 2;
    localparam int IDX_RF = 0;
    localparam int IDX_FB = 1;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] rise;
    logic            active;
    logic            idle;

    assign raw_in[IDX_RF] = ref_in;
    assign raw_in[IDX_FB] = fb_in;

    for (genvar g = 0; g < N_IN; g++) begin : g_in
        pfd_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_i    (raw_in[g]),
            .rise_o (rise[g])
        );
    end

    pfd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_rise_i (rise[IDX_RF]),
        .fb_rise_i  (rise[IDX_FB]),
        .corr_o     (corr_o),
        .active_o   (active),
        .idle_o     (idle)
    );

    pfd_lock_qual #(
        .LOCK_CYCLES (LOCK_CYCLES)
    ) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active),
        .ref_rise_i (rise[IDX_RF]),
        .lock_o     (lock_o)
    );

    assign pulse_o = idle;

    // R7
    no_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(corr_o[CORR_UP_BIT] && corr_o[CORR_DN_BIT]));

    // R8
    pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o == (corr_o == CODE_OFF));

endmodule

// File: tb/pfd_comparator_bench.sv
module pfd_comparator_bench;

    localparam int LOCK_N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic [1:0] corr_o;
    logic       pulse_o;
    logic       lock_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit seen_both = 1'b0;
    bit pulse_bad = 1'b0;

    always #10 clk = ~clk;

    pfd_comparator #(.SYNC_STAGES(2), .LOCK_CYCLES(LOCK_N)) u_pfd_comparator (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_in  (ref_in),
        .fb_in   (fb_in),
        .corr_o  (corr_o),
        .pulse_o (pulse_o),
        .lock_o  (lock_o)
    );

    // Continuous observation for R7 and R8, sampled on falling edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (corr_o == 2'b11) seen_both = 1'b1;
            if (pulse_o != (corr_o == 2'b00)) pulse_bad = 1'b1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic f);
        @(negedge clk);
        ref_in = r;
        fb_in  = f;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        ref_in = 1'b0;
        fb_in  = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
    endtask

    task automatic run_wave(input int periods, input int per, input int offs, input bit use_ref);
        for (int p = 0; p < periods; p++) begin
            for (int t = 0; t < per; t++) begin
                @(negedge clk);
                ref_in = use_ref && (t < per / 2);
                fb_in  = ((t + per - offs) % per) < per / 2;
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wait_n(2);
        check("R1 corr in reset", corr_o, 0);
        check("R1 lock in reset", lock_o, 0);
        do_reset();
        check("R1 corr after reset", corr_o, 0);
        check("R1 pulse after reset", pulse_o, 1);
        check("R1 lock after reset", lock_o, 0);
    endtask

    task automatic t_ref_first();
        do_reset();
        drive(1, 0);
        wait_n(2);
        check("R2 no early up", corr_o, 0);
        wait_n(1);
        check("R2 up asserted", corr_o, 2);
        check("R8 pulse low while up", pulse_o, 0);
        wait_n(5);
        check("R2 up held", corr_o, 2);
        drive(1, 1);
        wait_n(3);
        check("R4 up released by fb", corr_o, 0);
        check("R8 pulse high when idle", pulse_o, 1);
        drive(0, 0);
        wait_n(3);
    endtask

    task automatic t_fb_first();
        do_reset();
        drive(0, 1);
        wait_n(3);
        check("R3 down asserted", corr_o, 1);
        drive(1, 1);
        wait_n(3);
        check("R4 down released by ref", corr_o, 0);
        drive(0, 0);
        wait_n(3);
    endtask

    task automatic t_same_side();
        do_reset();
        drive(1, 0);
        wait_n(3);
        check("R5 up first", corr_o, 2);
        drive(0, 0);
        wait_n(3);
        check("R9 ref fall keeps up", corr_o, 2);
        drive(1, 0);
        wait_n(3);
        check("R5 second ref rise keeps up", corr_o, 2);
        drive(1, 1);
        wait_n(3);
        check("R4 release after repeats", corr_o, 0);
        drive(0, 0);
        wait_n(3);
    endtask

    task automatic t_simultaneous();
        bit bad = 1'b0;
        do_reset();
        drive(1, 1);
        for (int i = 0; i < 6; i++) begin
            wait_n(1);
            if (corr_o != 2'b00) bad = 1'b1;
        end
        check("R6 coincident rises stay idle", bad, 0);
    endtask

    task automatic t_falling();
        drive(0, 0);
        wait_n(4);
        check("R9 falling both no effect", corr_o, 0);
        drive(0, 1);
        wait_n(3);
        check("R3 down before fall", corr_o, 1);
        drive(0, 0);
        wait_n(4);
        check("R9 fb fall keeps down", corr_o, 1);
    endtask

    task automatic t_no_ref();
        bit bad = 1'b0;
        do_reset();
        drive(0, 1);
        wait_n(3);
        check("R10 down on fb only", corr_o, 1);
        for (int p = 0; p < 5; p++) begin
            for (int t = 0; t < 8; t++) begin
                @(negedge clk);
                if (corr_o != 2'b01) bad = 1'b1;
                fb_in = (t < 4);
            end
        end
        check("R10 down held without ref", bad, 0);
    endtask

    task automatic t_lock();
        do_reset();
        run_wave(LOCK_N - 1, 8, 0, 1);
        wait_n(4);
        check("R11 no lock before count", lock_o, 0);
        run_wave(1, 8, 0, 1);
        wait_n(1);
        check("R11 lock at count", lock_o, 1);
        run_wave(4, 8, 1, 1);
        wait_n(1);
        check("R12 one-clock pulses keep lock", lock_o, 1);
        run_wave(2, 8, 2, 1);
        wait_n(1);
        check("R12 two-clock pulse drops lock", lock_o, 0);
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_ref_first();
        t_fb_first();
        t_same_side();
        t_simultaneous();
        t_falling();
        t_no_ref();
        t_lock();
        check("R7 code 11 never seen", seen_both, 0);
        check("R8 pulse matches idle", pulse_bad, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule